// File: doc/BRIEF.md
# Two-Stage Scramble Key Fetch Sequencer

After reset this block collects two scramble keys from a one-time-programmable key store: first the key that scrambles addresses, then the key that scrambles data. Each key is fetched with its own four-phase request/acknowledge pair. Both fetches share a single response bus, which carries a key word, a random key word and a seed-valid flag. The block latches the words for the channel whose acknowledge is active, keeps a valid flag for each key, and raises a sticky completion flag once both exchanges are over.

The key store may run on a different clock, so the two acknowledges, the seed-valid flag and both response words pass through a synchronizer of two flops before the sequencer acts on them. If a store does not answer, the sequencer waits forever. A wait counter raises a sticky timeout flag when an acknowledge is late, and the exchange still completes if the acknowledge arrives afterwards.

Top module: `key_fetch_seq`

## Requirements
- R1: While rst_n is low, both requests, both key valid flags, fetch_done and ack_timeout are 0 and all four key words are zero. key_req_addr rises after the first rising clock edge at which rst_n is sampled high.
- R2: A request stays high until its synchronized acknowledge is seen high, then falls. The next phase begins only after that acknowledge is seen low again.
- R3: key_req_data rises only after the address exchange has fully finished, with its acknowledge seen low. The two requests are never high together.
- R4: When the synchronized acknowledge of the active channel is high and rsp_seed_ok is high, rsp_key and rsp_rkey are stored into that channel's key outputs and the channel's valid flag is set. The stored words then stay unchanged until reset.
- R5: If the active channel's acknowledge arrives while rsp_seed_ok is low, that channel's valid flag is 0, its words stay zero and the handshake still completes.
- R6: Each response input is seen by the sequencer on the third rising edge counting the edge at which it is first sampled, because it passes through two synchronizer flops.
- R7: fetch_done rises once the data acknowledge is seen low after the data request has dropped. It then stays high until reset.
- R8: While a request is high and its synchronized acknowledge is low, ack_timeout is set on the waiting edge that follows TIMEOUT_CYC earlier waiting edges of the same phase. It stays set until reset and does not stop the sequence.
- R9: An acknowledge on the channel that is not being requested has no effect on requests, key words or valid flags.
- R10: A reset applied after a completed fetch clears the key words, valid flags and fetch_done, and the sequence starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_req_addr | output | 1 | Request for the address-scrambling key |
| key_ack_addr | input | 1 | Acknowledge for the address key (asynchronous) |
| key_req_data | output | 1 | Request for the data-scrambling key |
| key_ack_data | input | 1 | Acknowledge for the data key (asynchronous) |
| rsp_seed_ok | input | 1 | Seed-valid flag on the shared response bus |
| rsp_key | input | KEY_W | Key word on the shared response bus |
| rsp_rkey | input | KEY_W | Random key word on the shared response bus |
| addr_key | output | KEY_W | Stored address key word |
| addr_rkey | output | KEY_W | Stored address random key word |
| addr_key_ok | output | 1 | Address key stored with seed valid |
| data_key | output | KEY_W | Stored data key word |
| data_rkey | output | KEY_W | Stored data random key word |
| data_key_ok | output | 1 | Data key stored with seed valid |
| fetch_done | output | 1 | Both exchanges finished (sticky) |
| ack_timeout | output | 1 | An acknowledge was late (sticky) |

## Verification
The timeout counter and the arrival of an acknowledge can meet on the same edge. If the synchronized acknowledge is seen exactly at the edge where the wait limit would be reached, the flag must stay low and the request must drop. The bench causes this by sweeping the acknowledge delay of the address exchange across the limit, one cycle at a time, with a reduced TIMEOUT_CYC. On every clock it compares the flag, the requests and the stored keys with a behavioural model that delays the inputs through a queue.

// File: rtl/kf_pkg.sv
// Package: shared state encoding for the key fetch sequencer.
// Assumes: the address exchange always precedes the data exchange.
package kf_pkg;

    typedef enum logic [2:0] {
        KF_IDLE     = 3'd0,
        KF_ADDR_REQ = 3'd1,
        KF_ADDR_REL = 3'd2,
        KF_DATA_REQ = 3'd3,
        KF_DATA_REL = 3'd4,
        KF_DONE     = 3'd5
    } kf_state_e;

    localparam int unsigned KF_NUM_CH = 2;
    localparam int unsigned KF_CH_ADDR = 0;
    localparam int unsigned KF_CH_DATA = 1;

endpackage

// File: rtl/kf_sync.sv
// Module: multi-flop synchronizer for a vector of slow-changing inputs.
// Assumes: the data bits are stable while their qualifying flag is high,
// so one plain flop chain per bit suffices. Reset clears all stages.
module kf_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw input into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                // Shift the value one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/kf_seq_fsm.sv
// Module: sequencer of the two four-phase key exchanges.
// Assumes: acknowledges arrive already synchronized; only the acknowledge of
// the channel currently in its request phase is looked at.
module kf_seq_fsm
    import kf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack_addr_s,
    input  logic ack_data_s,
    output logic req_addr,
    output logic req_data,
    output logic cap_addr,
    output logic cap_data,
    output logic in_req,
    output logic waiting,
    output logic done
);
    kf_state_e state_q, state_d;

    // Next-state selection for the fetch sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KF_IDLE:     state_d = KF_ADDR_REQ;
            KF_ADDR_REQ: if (ack_addr_s)  state_d = KF_ADDR_REL;
            KF_ADDR_REL: if (!ack_addr_s) state_d = KF_DATA_REQ;
            KF_DATA_REQ: if (ack_data_s)  state_d = KF_DATA_REL;
            KF_DATA_REL: if (!ack_data_s) state_d = KF_DONE;
            KF_DONE:     state_d = KF_DONE;
            default:     state_d = KF_IDLE;
        endcase
    end

    // State register, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KF_IDLE;
        else        state_q <= state_d;
    end

    // Decode requests, capture strobes and wait qualifiers from the state.
    always_comb begin
        req_addr = (state_q == KF_ADDR_REQ);
        req_data = (state_q == KF_DATA_REQ);
        cap_addr = req_addr && ack_addr_s;
        cap_data = req_data && ack_data_s;
        in_req   = req_addr || req_data;
        waiting  = (req_addr && !ack_addr_s) || (req_data && !ack_data_s);
        done     = (state_q == KF_DONE);
    end
endmodule

// File: rtl/kf_key_slot.sv
// Module: storage for one key pair and its valid flag.
// Assumes: cap pulses for one cycle per exchange; words are only written when
// the seed flag is high, otherwise the slot is marked invalid.
module kf_key_slot #(
    parameter int unsigned KEY_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic             seed_ok,
    input  logic [KEY_W-1:0] key_in,
    input  logic [KEY_W-1:0] rkey_in,
    output logic [KEY_W-1:0] key_q,
    output logic [KEY_W-1:0] rkey_q,
    output logic             ok_q
);
    // Latch the words on a qualified capture; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q  <= '0;
            rkey_q <= '0;
        end else if (cap && seed_ok) begin
            key_q  <= key_in;
            rkey_q <= rkey_in;
        end
    end

    // Track whether the stored pair came with a valid seed.
    always_ff @(posedge clk) begin
        if (!rst_n)   ok_q <= 1'b0;
        else if (cap) ok_q <= seed_ok;
    end
endmodule

// File: rtl/kf_wait_timer.sv
// Module: counts waiting cycles in a request phase and flags a late acknowledge.
// Assumes: in_req drops between phases, which restarts the count.
module kf_wait_timer #(
    parameter int unsigned LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_req,
    input  logic waiting,
    output logic err
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;
    logic             at_limit;

    assign at_limit = (cnt_q == CNT_MAX);

    // Count waiting edges of the current request phase, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_req)     cnt_q <= '0;
        else if (waiting && !at_limit) cnt_q <= cnt_q + 1'b1;
    end

    // Sticky error once a phase waits past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                           err <= 1'b0;
        else if (in_req && waiting && at_limit) err <= 1'b1;
    end
endmodule

// File: rtl/key_fetch_seq.sv
// Module: top of the two-stage scramble key fetch sequencer.
// Assumes: a key store on a possibly different clock answers each request with
// a four-phase handshake on a shared response bus (key, random key, seed flag).
module key_fetch_seq
    import kf_pkg::*;
#(
    parameter int unsigned KEY_W       = 128,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned TIMEOUT_CYC = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             key_req_addr,
    input  logic             key_ack_addr,
    output logic             key_req_data,
    input  logic             key_ack_data,
    input  logic             rsp_seed_ok,
    input  logic [KEY_W-1:0] rsp_key,
    input  logic [KEY_W-1:0] rsp_rkey,
    output logic [KEY_W-1:0] addr_key,
    output logic [KEY_W-1:0] addr_rkey,
    output logic             addr_key_ok,
    output logic [KEY_W-1:0] data_key,
    output logic [KEY_W-1:0] data_rkey,
    output logic             data_key_ok,
    output logic             fetch_done,
    output logic             ack_timeout
);
    localparam int unsigned SYNC_W = 3 + 2 * KEY_W;

    logic [SYNC_W-1:0] raw_bus, sync_bus;
    logic              ack_addr_s, ack_data_s, seed_s;
    logic [KEY_W-1:0]  key_s, rkey_s;
    logic              cap_addr, cap_data, in_req, waiting;

    logic              slot_cap  [KF_NUM_CH];
    logic [KEY_W-1:0]  slot_key  [KF_NUM_CH];
    logic [KEY_W-1:0]  slot_rkey [KF_NUM_CH];
    logic              slot_ok   [KF_NUM_CH];

    // Bundle every response input for the synchronizer.
    assign raw_bus = {key_ack_addr, key_ack_data, rsp_seed_ok, rsp_key, rsp_rkey};

    kf_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_bus),
        .q_sync  (sync_bus)
    );

    assign {ack_addr_s, ack_data_s, seed_s, key_s, rkey_s} = sync_bus;

    kf_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_addr_s (ack_addr_s),
        .ack_data_s (ack_data_s),
        .req_addr   (key_req_addr),
        .req_data   (key_req_data),
        .cap_addr   (cap_addr),
        .cap_data   (cap_data),
        .in_req     (in_req),
        .waiting    (waiting),
        .done       (fetch_done)
    );

    kf_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_req  (in_req),
        .waiting (waiting),
        .err     (ack_timeout)
    );

    assign slot_cap[KF_CH_ADDR] = cap_addr;
    assign slot_cap[KF_CH_DATA] = cap_data;

    generate
        for (genvar c = 0; c < KF_NUM_CH; c++) begin : g_slot
            kf_key_slot #(.KEY_W(KEY_W)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .cap     (slot_cap[c]),
                .seed_ok (seed_s),
                .key_in  (key_s),
                .rkey_in (rkey_s),
                .key_q   (slot_key[c]),
                .rkey_q  (slot_rkey[c]),
                .ok_q    (slot_ok[c])
            );
        end
    endgenerate

    assign addr_key    = slot_key[KF_CH_ADDR];
    assign addr_rkey   = slot_rkey[KF_CH_ADDR];
    assign addr_key_ok = slot_ok[KF_CH_ADDR];
    assign data_key    = slot_key[KF_CH_DATA];
    assign data_rkey   = slot_rkey[KF_CH_DATA];
    assign data_key_ok = slot_ok[KF_CH_DATA];
endmodule

// File: rtl/kf_checker.sv
// Module: protocol checks for key_fetch_seq, attached with bind.
// Assumes: it sees the synchronized acknowledges of the top module.
module kf_checker #(
    parameter int unsigned KEY_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_addr,
    input logic             req_data,
    input logic             ack_addr_s,
    input logic             ack_data_s,
    input logic [KEY_W-1:0] addr_key,
    input logic [KEY_W-1:0] data_key,
    input logic             done,
    input logic             timeout
);
    p_req_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_addr && req_data));

    p_addr_drop_on_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_addr) |-> $past(ack_addr_s));

    p_data_rise_after_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_data) |-> $past(!ack_addr_s));

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!req_addr && !req_data && $past(!ack_data_s)));

    p_keys_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(addr_key) && $stable(data_key)));

    p_timeout_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> timeout);
endmodule

bind key_fetch_seq kf_checker #(.KEY_W(KEY_W)) u_kf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_addr   (key_req_addr),
    .req_data   (key_req_data),
    .ack_addr_s (ack_addr_s),
    .ack_data_s (ack_data_s),
    .addr_key   (addr_key),
    .data_key   (data_key),
    .done       (fetch_done),
    .timeout    (ack_timeout)
);

// File: tb/tb_key_fetch_seq.sv
module tb_key_fetch_seq;
    localparam int CLK_PERIOD = 10;
    localparam int KW = 128;
    localparam int TO = 12;
    localparam int QW = 3 + 2 * KW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ack_a = 1'b0, ack_d = 1'b0, seed = 1'b0;
    logic [KW-1:0] kbus = '0, rbus = '0;
    logic          req_a, req_d, ok_a, ok_d, done, terr;
    logic [KW-1:0] ka, ra, kd, rd;

    int n_chk = 0, n_bad = 0, cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    key_fetch_seq #(.KEY_W(KW), .SYNC_STAGES(2), .TIMEOUT_CYC(TO)) dut (
        .clk(clk), .rst_n(rst_n),
        .key_req_addr(req_a), .key_ack_addr(ack_a),
        .key_req_data(req_d), .key_ack_data(ack_d),
        .rsp_seed_ok(seed), .rsp_key(kbus), .rsp_rkey(rbus),
        .addr_key(ka), .addr_rkey(ra), .addr_key_ok(ok_a),
        .data_key(kd), .data_rkey(rd), .data_key_ok(ok_d),
        .fetch_done(done), .ack_timeout(terr)
    );

    // Behavioural reference: inputs delayed through a queue, phase as an integer.
    logic [QW-1:0] hist[$];
    logic [QW-1:0] seen;
    int            ph = 0, wc = 0;
    logic          m_err = 0, m_oka = 0, m_okd = 0;
    logic [KW-1:0] m_ka = '0, m_ra = '0, m_kd = '0, m_rd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            ph = 0; wc = 0; m_err = 0; m_oka = 0; m_okd = 0;
            m_ka = '0; m_ra = '0; m_kd = '0; m_rd = '0;
        end else begin
            seen = (hist.size() >= 2) ? hist[0] : '0;
            hist.push_back({ack_a, ack_d, seed, kbus, rbus});
            if (hist.size() > 2) void'(hist.pop_front());
            case (ph)
                0: begin ph = 1; wc = 0; end
                1: if (seen[QW-1]) begin
                       if (seen[QW-3]) begin m_ka = seen[2*KW-1:KW]; m_ra = seen[KW-1:0]; end
                       m_oka = seen[QW-3]; ph = 2; wc = 0;
                   end else if (wc == TO) m_err = 1; else wc++;
                2: if (!seen[QW-1]) ph = 3;
                3: if (seen[QW-2]) begin
                       if (seen[QW-3]) begin m_kd = seen[2*KW-1:KW]; m_rd = seen[KW-1:0]; end
                       m_okd = seen[QW-3]; ph = 4; wc = 0;
                   end else if (wc == TO) m_err = 1; else wc++;
                4: if (!seen[QW-2]) ph = 5;
                default: ph = 5;
            endcase
        end
    end

    task automatic chk(input string req, input string what, input logic [KW-1:0] act,
                       input logic [KW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    // Compare the design with the reference on every falling edge.
    always @(negedge clk) begin
        cyc++;
        chk("R2", "key_req_addr", KW'(req_a), KW'(ph == 1));
        chk("R3", "key_req_data", KW'(req_d), KW'(ph == 3));
        chk("R4", "addr_key", ka, m_ka);
        chk("R4", "addr_rkey", ra, m_ra);
        chk("R4", "data_key", kd, m_kd);
        chk("R4", "data_rkey", rd, m_rd);
        chk("R5", "addr_key_ok", KW'(ok_a), KW'(m_oka));
        chk("R5", "data_key_ok", KW'(ok_d), KW'(m_okd));
        chk("R7", "fetch_done", KW'(done), KW'(ph == 5));
        chk("R8", "ack_timeout", KW'(terr), KW'(m_err));
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ack_a = 0; ack_d = 0; seed = 0;
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        chk("R1", "reset req", KW'({req_a, req_d}), '0);
        chk("R10", "reset keys", ka | ra | kd | rd, '0);
        chk("R1", "reset flags", KW'({ok_a, ok_d, done, terr}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "first request", KW'(req_a), KW'(1));
    endtask

    // Provider side of one exchange; which = 0 address, 1 data.
    task automatic serve(input int which, input int dly, input logic sd,
                         input logic [KW-1:0] k, input logic [KW-1:0] r);
        while (!(which == 0 ? req_a : req_d)) @(negedge clk);
        repeat (dly) @(negedge clk);
        kbus = k; rbus = r; seed = sd;
        if (which == 0) ack_a = 1; else ack_d = 1;
        while (which == 0 ? req_a : req_d) @(negedge clk);
        if (which == 0) ack_a = 0; else ack_d = 0;
        seed = 0;
        kbus = ~k; rbus = ~r;
    endtask

    localparam logic [KW-1:0] KA = {4{32'h1357_9bdf}};
    localparam logic [KW-1:0] RA = {4{32'h2468_ace0}};
    localparam logic [KW-1:0] KD = {4{32'hdead_0001}};
    localparam logic [KW-1:0] RD = {4{32'h0bad_cafe}};

    initial begin
        // Normal fetch of both keys (R4, R7, R6 latency through the model)
        do_reset();
        serve(0, 2, 1'b1, KA, RA);
        serve(1, 3, 1'b1, KD, RD);
        repeat (6) @(negedge clk);
        chk("R4", "addr key final", ka, KA);
        chk("R4", "data rkey final", rd, RD);
        chk("R7", "done final", KW'(done), KW'(1));
        repeat (5) @(negedge clk);
        chk("R7", "done held", KW'(done), KW'(1));

        // Reset after completion clears everything (R10)
        do_reset();
        chk("R10", "keys cleared", ka | kd, '0);

        // Address acknowledge without seed (R5)
        serve(0, 1, 1'b0, KA, RA);
        serve(1, 1, 1'b1, KD, RD);
        repeat (6) @(negedge clk);
        chk("R5", "addr ok low", KW'(ok_a), KW'(0));
        chk("R5", "addr key zero", ka, '0);
        chk("R5", "data ok high", KW'(ok_d), KW'(1));

        // Wrong-channel acknowledge during the address phase (R9)
        do_reset();
        kbus = KD; rbus = RD; seed = 1; ack_d = 1;
        repeat (5) @(negedge clk);
        chk("R9", "req_addr held", KW'(req_a), KW'(1));
        chk("R9", "data key untouched", kd, '0);
        ack_d = 0; seed = 0;
        repeat (4) @(negedge clk);
        serve(0, 0, 1'b1, KA, RA);
        serve(1, 0, 1'b1, KD, RD);
        repeat (6) @(negedge clk);
        chk("R9", "addr key after stray", ka, KA);

        // Timeout boundary sweep: ack arrival meets the wait limit (R8)
        for (int d = TO - 4; d <= TO + 1; d++) begin
            do_reset();
            serve(0, d, 1'b1, KA, RA);
            serve(1, 1, 1'b1, KD, RD);
            repeat (6) @(negedge clk);
            chk("R8", "sequence completes", KW'(done), KW'(1));
        end

        // Long data-side wait raises the flag and still finishes (R8)
        do_reset();
        serve(0, 0, 1'b1, KA, RA);
        serve(1, TO + 8, 1'b1, KD, RD);
        repeat (6) @(negedge clk);
        chk("R8", "timeout raised", KW'(terr), KW'(1));
        chk("R8", "done after timeout", KW'(done), KW'(1));
        chk("R4", "data key after timeout", kd, KD);

        finish_run();
    end
endmodule